// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block is an eight-pin general-purpose I/O port whose pins are each shaped by a small bank of configuration registers. A host reads and writes those registers over a plain synchronous bus. It presents a write strobe, an offset and write data, and it reads back through a combinational read-data path. Each pin can take its output value either from the host's data-out register or from an address-out bit. Its drive can be enabled either by an external programmable-logic output-enable term or by a direction bit. Its driver can act as push-pull or open drain, and on pins that cannot be open drain the same bit selects a fast output edge rate.

The pad side is combinational from the registers and the external terms. The pad input levels are brought into the clock domain through two flops before the host can read them. Parameters set the port width, whether the address-out mode register exists, which direction bits are implemented, and which pins support open drain. The host bus has no back-pressure: every write strobe is accepted on the edge where it is seen, and read data is valid in the same cycle as its offset.

Top module: `gpio_cfg_port`

## Requirements
- R1: On reset every configuration register and the input synchronizer are cleared to 0. The port then drives no pin (pad_oe = 0), reports slow edges (pad_fast = 0) and presents pad_out = 0.
- R2: A write takes effect on the rising edge where bus_we is 1. The offsets are 0 for data-out, 1 for the mode register, 2 for direction and 3 for drive select. Reading any of these offsets returns the register's current value.
- R3: Mode bit n at 1 makes pin n output addr_bits[n], and at 0 makes it output data-out bit n. With HAS_MODE = 0 the mode register reads 0, ignores writes, and every pin carries host data.
- R4: Direction bit n at 1 enables pin n's driver, and at 0 leaves the pin an input, as long as pld_oe[n] is 0.
- R5: pld_oe[n] at 1 enables pin n's driver whatever its direction bit holds.
- R6: On a pin whose OD_MASK bit is 1 and whose drive-select bit is 1, pad_out is 0. A source value of 0 enables the driver, and a source value of 1 releases the pin (pad_oe = 0).
- R7: On a pin whose OD_MASK bit is 0, drive-select bit 1 sets pad_fast. Open-drain-capable pins always report pad_fast = 0.
- R8: Direction bits whose DIR_MASK bit is 0 are not implemented. They read back as 0 and never enable a driver.
- R9: Reading offset 4 returns pad_in through two flops. A change at the pads is visible on a read after the second rising edge and not after the first.
- R10: A cycle with bus_we at 0, or a write to offset 4 or above, changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data for bus_addr, combinational |
| pld_oe | input | WIDTH | External per-pin output-enable terms |
| addr_bits | input | WIDTH | Address bits for address-out mode |
| pad_in | input | WIDTH | Pad input levels, asynchronous |
| pad_out | output | WIDTH | Pad output values |
| pad_oe | output | WIDTH | Pad driver enables |
| pad_fast | output | WIDTH | Fast edge-rate selects |

## Verification
On every cycle the assertions check several rules. Registers are clear on the edge where reset is released. A direction write lands masked on the next edge, and the configuration holds still while no write is strobed. A pin whose product term or direction bit is set is never left undriven unless open drain releases it, an open-drain pin never presents a high, and unimplemented direction bits stay zero. Only the bench's scenarios can show the pin-by-pin mixing of data sources and drive modes. The same holds for the exact two-edge latency of the input path and for the behaviour of the reduced variant without a mode register.

// File: rtl/gpio_cfg_pkg.sv
package gpio_cfg_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    OFS_DOUT  = 3'd0,
    OFS_MODE  = 3'd1,
    OFS_DIR   = 3'd2,
    OFS_DRIVE = 3'd3,
    OFS_DIN   = 3'd4
  } ofs_e;
endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_cfg_pkg::*;
#(
  parameter int               WIDTH    = 8,
  parameter bit               HAS_MODE = 1'b1,
  parameter logic [WIDTH-1:0] DIR_MASK = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  dout_q,
  output logic [WIDTH-1:0]  mode_q,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  drive_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q  <= '0;
      dir_q   <= '0;
      drive_q <= '0;
    end else if (we) begin
      case (addr)
        OFS_DOUT:  dout_q  <= wdata;
        OFS_DIR:   dir_q   <= wdata & DIR_MASK;
        OFS_DRIVE: drive_q <= wdata;
        default: ;
      endcase
    end
  end

  generate
    if (HAS_MODE) begin : g_mode
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       mode_q <= '0;
        else if (we && addr == OFS_MODE)  mode_q <= wdata;
      end
    end else begin : g_no_mode
      assign mode_q = '0;
    end
  endgenerate
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter int               WIDTH   = 8,
  parameter logic [WIDTH-1:0] OD_MASK = '0
) (
  input  logic [WIDTH-1:0] dout_q,
  input  logic [WIDTH-1:0] mode_q,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] drive_q,
  input  logic [WIDTH-1:0] pld_oe,
  input  logic [WIDTH-1:0] addr_bits,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_fast
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic src, en;
    assign src = mode_q[i] ? addr_bits[i] : dout_q[i];
    assign en  = pld_oe[i] | dir_q[i];

    if (OD_MASK[i]) begin : g_od
      assign pad_out[i]  = drive_q[i] ? 1'b0 : src;
      assign pad_oe[i]   = drive_q[i] ? (en & ~src) : en;
      assign pad_fast[i] = 1'b0;
    end else begin : g_pp
      assign pad_out[i]  = src;
      assign pad_oe[i]   = en;
      assign pad_fast[i] = drive_q[i];
    end
  end
endmodule

// File: rtl/gpio_cfg_port.sv
module gpio_cfg_port
  import gpio_cfg_pkg::*;
#(
  parameter int               WIDTH    = 8,
  parameter bit               HAS_MODE = 1'b1,
  parameter logic [WIDTH-1:0] DIR_MASK = '1,
  parameter logic [WIDTH-1:0] OD_MASK  = 8'h0F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pld_oe,
  input  logic [WIDTH-1:0]  addr_bits,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe,
  output logic [WIDTH-1:0]  pad_fast
);
  logic [WIDTH-1:0] dout_q, mode_q, dir_q, drive_q, din_q;

  gpio_cfg_regs #(.WIDTH(WIDTH), .HAS_MODE(HAS_MODE), .DIR_MASK(DIR_MASK)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .dout_q(dout_q), .mode_q(mode_q), .dir_q(dir_q), .drive_q(drive_q)
  );

  gpio_in_sync #(.WIDTH(WIDTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(din_q)
  );

  gpio_pin_mux #(.WIDTH(WIDTH), .OD_MASK(OD_MASK)) u_mux (
    .dout_q(dout_q), .mode_q(mode_q), .dir_q(dir_q), .drive_q(drive_q),
    .pld_oe(pld_oe), .addr_bits(addr_bits),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_fast(pad_fast)
  );

  always_comb begin
    case (bus_addr)
      OFS_DOUT:  bus_rdata = dout_q;
      OFS_MODE:  bus_rdata = mode_q;
      OFS_DIR:   bus_rdata = dir_q;
      OFS_DRIVE: bus_rdata = drive_q;
      OFS_DIN:   bus_rdata = din_q;
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_cfg_port_chk.sv
module gpio_cfg_port_chk #(
  parameter int               WIDTH    = 8,
  parameter logic [WIDTH-1:0] DIR_MASK = '1,
  parameter logic [WIDTH-1:0] OD_MASK  = 8'h0F
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_we,
  input logic [2:0]       bus_addr,
  input logic [WIDTH-1:0] bus_wdata,
  input logic [WIDTH-1:0] dout_q,
  input logic [WIDTH-1:0] mode_q,
  input logic [WIDTH-1:0] dir_q,
  input logic [WIDTH-1:0] drive_q,
  input logic [WIDTH-1:0] pld_oe,
  input logic [WIDTH-1:0] pad_out,
  input logic [WIDTH-1:0] pad_oe
);
  logic [WIDTH-1:0] od_on;
  assign od_on = drive_q & OD_MASK;

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (dout_q == '0 && mode_q == '0 && dir_q == '0 && drive_q == '0));

  assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 3'd2) |=> (dir_q == ($past(bus_wdata) & DIR_MASK)));

  assert_dir_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_q & ~od_on & ~pad_oe) == '0);

  assert_pld_drives_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pld_oe & ~od_on & ~pad_oe) == '0);

  assert_od_never_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (od_on & pad_out) == '0);

  assert_dir_unimpl_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_q & ~DIR_MASK) == '0);

  assert_hold_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> ($stable(dout_q) && $stable(mode_q) && $stable(dir_q) && $stable(drive_q)));
endmodule

bind gpio_cfg_port gpio_cfg_port_chk #(.WIDTH(WIDTH), .DIR_MASK(DIR_MASK), .OD_MASK(OD_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .dout_q(dout_q), .mode_q(mode_q), .dir_q(dir_q), .drive_q(drive_q),
  .pld_oe(pld_oe), .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/gpio_cfg_port_tb.sv
`timescale 1ns/1ps
module gpio_cfg_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, pld_oe = '0, addr_bits = '0, pad_in = '0;
  logic [7:0] rdata, pad_out, pad_oe, pad_fast;
  logic [7:0] n_rdata, n_out, n_oe, n_fast;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_cfg_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rdata), .pld_oe(pld_oe), .addr_bits(addr_bits), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_fast(pad_fast));

  gpio_cfg_port #(.HAS_MODE(1'b0), .DIR_MASK(8'h03)) u_narrow (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(n_rdata), .pld_oe(pld_oe), .addr_bits(addr_bits), .pad_in(pad_in),
    .pad_out(n_out), .pad_oe(n_oe), .pad_fast(n_fast));

  typedef struct packed {
    logic [7:0] dout, mode, dir, drv, oe, ab, x_out, x_oe, x_fast;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{8'hA5, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h00, 8'hA5, 8'hFF, 8'h00},
    '{8'hA5, 8'hF0, 8'h0F, 8'h00, 8'h00, 8'h3C, 8'h35, 8'h0F, 8'h00},
    '{8'h5A, 8'h00, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h50, 8'hF5, 8'hF0},
    '{8'hFF, 8'h00, 8'h00, 8'h00, 8'hC3, 8'h00, 8'hFF, 8'hC3, 8'h00},
    '{8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h00, 8'h00},
    '{8'h00, 8'hFF, 8'hFF, 8'h0F, 8'h00, 8'h96, 8'h90, 8'hF9, 8'h00}
  };

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [2:0] a, logic [7:0] exp);
    bus_addr = a; #1;
    chk(req, rdata, exp);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    for (int a = 0; a < 5; a++) rd_chk("R1 reg", 3'(a), 8'h00);
    chk("R1 pad_oe", pad_oe, 8'h00);
    chk("R1 pad_fast", pad_fast, 8'h00);
    chk("R1 pad_out", pad_out, 8'h00);

    // Vector walk: R3 R4 R5 R6 R7
    for (int v = 0; v < 6; v++) begin
      wr(3'd0, VEC[v].dout); wr(3'd1, VEC[v].mode);
      wr(3'd2, VEC[v].dir);  wr(3'd3, VEC[v].drv);
      pld_oe = VEC[v].oe; addr_bits = VEC[v].ab; #1;
      chk("R3/R6 pad_out", pad_out, VEC[v].x_out);
      chk("R4/R5/R6 pad_oe", pad_oe, VEC[v].x_oe);
      chk("R7 pad_fast", pad_fast, VEC[v].x_fast);
    end

    // R2: readback of last vector
    rd_chk("R2 dout", 3'd0, 8'h00);
    rd_chk("R2 mode", 3'd1, 8'hFF);
    rd_chk("R2 dir", 3'd2, 8'hFF);
    rd_chk("R2 drive", 3'd3, 8'h0F);

    // R10: no strobe, and write to data-in offset
    @(negedge clk);
    bus_addr = 3'd2; bus_wdata = 8'h55;
    @(negedge clk); @(negedge clk);
    rd_chk("R10 no strobe", 3'd2, 8'hFF);
    wr(3'd4, 8'hAA);
    rd_chk("R10 din write", 3'd4, 8'h00);
    rd_chk("R10 dout kept", 3'd0, 8'h00);

    // R9: two-flop latency
    bus_addr = 3'd4;
    pad_in = 8'h3C;
    @(negedge clk); #1;
    chk("R9 after one edge", rdata, 8'h00);
    @(negedge clk); #1;
    chk("R9 after two edges", rdata, 8'h3C);

    // R3/R8: reduced variant without mode register
    wr(3'd3, 8'h00); wr(3'd2, 8'hFF); wr(3'd1, 8'hFF); wr(3'd0, 8'h0F);
    pld_oe = 8'h00; addr_bits = 8'hF0;
    bus_addr = 3'd2; #1;
    chk("R8 narrow dir read", n_rdata, 8'h03);
    chk("R8 narrow pad_oe", n_oe, 8'h03);
    bus_addr = 3'd1; #1;
    chk("R3 narrow mode read", n_rdata, 8'h00);
    chk("R3 narrow pad_out", n_out, 8'h0F);
    chk("R3 full pad_out", pad_out, 8'hF0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule